// File: doc/BRIEF.md
# Ring-Snooping MSI Cache Node

This block is one cache node on a unidirectional message ring. It keeps a small direct-mapped, one-word-per-line cache coherent with its peers using the Invalid, Shared and Modified states. A CPU issues loads and stores to it. Hits are answered locally. Misses, and stores to Shared lines, become ring requests that travel the whole ring and come back to the sender. On the way, every other node snoops the request, attaches its data and changes its own line state where needed.

A node may put a new request on the ring only while it holds a circulating token. Each token covers a disjoint group of line addresses, chosen by the low address bits. A pending counter (0, 1 or 2) tracks how many of the node's own messages are still travelling. The node keeps the token until that counter falls back to zero, and then releases it to the next node. Every message carries an opcode, an address, a data word, a data-valid flag and the index of the node that sent it. The node recognises its own returning traffic by comparing that index with its `NODE_ID` parameter.

Top module: `rcn_node`

## Requirements
- R1: After reset every line is Invalid, pending is 0, no CPU response and no ring message is produced, and both `cpu_req_ready` and `ring_in_ready` are high.
- R2: A load that hits a Shared or Modified line, or a store that hits a Modified line, is answered one cycle after acceptance with no ring message. A store writes its data into the line and is answered with that data.
- R3: A load that misses (Invalid line or tag mismatch), or a store to a non-Modified line, gets no immediate answer. When a matching token arrives with pending 0, the node consumes the token and, one cycle later, emits a Read (op 0) or Write (op 1) with the request address, data-valid 0 and source `NODE_ID`. Pending becomes 1.
- R4: A token message has op 3 and carries its token number in the address field. Token t serves addresses whose value modulo `NUM_TOK` equals t. A token that is not needed, or that serves another group, is forwarded unchanged one cycle later.
- R5: A Read or Write from another node that misses in this cache, and every WriteBack (op 2) from another node, are forwarded unchanged one cycle later.
- R6: A foreign Read that hits gets this line's data attached with data-valid 1. A Modified line drops to Shared, so a later store to it must go to the ring again.
- R7: A foreign Write that hits a Shared or Modified line gets the data attached with data-valid 1, and the line becomes Invalid, so a later load to it misses.
- R8: When the node's own Read returns, the carried data is installed as Shared and returned to the CPU. A WriteBack with that address, that data, data-valid 1 and source `NODE_ID` is emitted one cycle later.
- R9: When the node's own Write returns, the store data is installed as Modified and returned to the CPU, and a WriteBack carrying the store data is emitted.
- R10: If that install displaces a Modified line with another tag, a second WriteBack carrying the victim address and data follows in the next cycle. `ring_in_ready` is low for that one cycle, and pending becomes 2.
- R11: The node consumes its own returning WriteBack. Pending 2 drops to 1 with no output. Pending 1 drops to 0, and the held token (op 3, its number in the address field) is emitted one cycle later.
- R12: `cpu_req_ready` is low while pending is nonzero or a request is waiting for a token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | Node can take a CPU request |
| cpu_req_store | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_data | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | Response pulse |
| cpu_rsp_data | output | DATA_W | Load data or stored value |
| ring_in_valid | input | 1 | Incoming ring message present |
| ring_in_ready | output | 1 | Node can take a ring message |
| ring_in_op | input | 2 | 0 Read, 1 Write, 2 WriteBack, 3 token |
| ring_in_addr | input | ADDR_W | Address or token number |
| ring_in_data | input | DATA_W | Data word |
| ring_in_dv | input | 1 | Data word is valid |
| ring_in_src | input | SRC_W | Originating node index |
| ring_out_valid | output | 1 | Outgoing ring message present |
| ring_out_op | output | 2 | Opcode, same encoding |
| ring_out_addr | output | ADDR_W | Address or token number |
| ring_out_data | output | DATA_W | Data word |
| ring_out_dv | output | 1 | Data word is valid |
| ring_out_src | output | SRC_W | Originating node index |

## Verification
Loads are swept across every line index to fill the cache. Foreign Reads are then swept over hitting and non-hitting addresses, which tells an attach-and-forward apart from an untouched pass-through. Stores are run against Shared, Modified and tag-conflicting lines, which separates the local hit, the upgrade through the ring and the double-WriteBack eviction with its one-cycle input stall. Foreign Reads and Writes are followed by CPU accesses to the same line, so the resulting downgrade and invalidation show up at the CPU port as a missing immediate answer. Tokens of the wrong group are sent ahead of the right one to show that only a token for the request's address group is consumed.

// File: rtl/rcn_pkg.sv
package rcn_pkg;

    parameter int ADDR_W = 8;
    parameter int DATA_W = 16;
    parameter int SRC_W  = 4;

    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_WR  = 2'd1,
        OP_WB  = 2'd2,
        OP_TOK = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_M = 2'd2
    } lstate_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              dv;
        logic [SRC_W-1:0]  src;
    } msg_t;

    function automatic msg_t mk_msg(op_e op, logic [ADDR_W-1:0] a,
                                    logic [DATA_W-1:0] d, logic dv,
                                    logic [SRC_W-1:0] s);
        msg_t m;
        m.op   = op;
        m.addr = a;
        m.data = d;
        m.dv   = dv;
        m.src  = s;
        return m;
    endfunction

endpackage

// File: rtl/rcn_line_store.sv
module rcn_line_store
    import rcn_pkg::*;
#(
    parameter int LINES = 4,
    parameter int IDX_W = 2,
    parameter int TAG_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  a_idx,
    output lstate_e           a_st,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output lstate_e           b_st,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              st_we,
    input  logic [IDX_W-1:0]  st_idx,
    input  lstate_e           st_val,
    input  logic              dt_we,
    input  logic [IDX_W-1:0]  dt_idx,
    input  logic [DATA_W-1:0] dt_val,
    input  logic              tg_we,
    input  logic [IDX_W-1:0]  tg_idx,
    input  logic [TAG_W-1:0]  tg_val
);

    lstate_e           st_arr [LINES];
    logic [TAG_W-1:0]  tg_arr [LINES];
    logic [DATA_W-1:0] dt_arr [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        lstate_e           st_r;
        logic [TAG_W-1:0]  tg_r;
        logic [DATA_W-1:0] dt_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                st_r <= LS_I;
                tg_r <= '0;
                dt_r <= '0;
            end else begin
                if (st_we && st_idx == IDX_W'(g)) st_r <= st_val;
                if (tg_we && tg_idx == IDX_W'(g)) tg_r <= tg_val;
                if (dt_we && dt_idx == IDX_W'(g)) dt_r <= dt_val;
            end
        end

        assign st_arr[g] = st_r;
        assign tg_arr[g] = tg_r;
        assign dt_arr[g] = dt_r;
    end

    assign a_st   = st_arr[a_idx];
    assign a_tag  = tg_arr[a_idx];
    assign a_data = dt_arr[a_idx];
    assign b_st   = st_arr[b_idx];
    assign b_tag  = tg_arr[b_idx];
    assign b_data = dt_arr[b_idx];

endmodule

// File: rtl/rcn_snoop.sv
module rcn_snoop
    import rcn_pkg::*;
(
    input  msg_t              in_msg,
    input  logic              hit,
    input  lstate_e           cur_st,
    input  logic [DATA_W-1:0] cur_data,
    output msg_t              out_msg,
    output logic              st_we,
    output lstate_e           st_new
);

    always_comb begin
        out_msg = in_msg;
        st_we   = 1'b0;
        st_new  = cur_st;
        if (hit) begin
            unique case (in_msg.op)
                OP_RD: begin
                    out_msg.data = cur_data;
                    out_msg.dv   = 1'b1;
                    if (cur_st == LS_M) begin
                        st_we  = 1'b1;
                        st_new = LS_S;
                    end
                end
                OP_WR: begin
                    out_msg.data = cur_data;
                    out_msg.dv   = 1'b1;
                    st_we        = 1'b1;
                    st_new       = LS_I;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rcn_node.sv
module rcn_node
    import rcn_pkg::*;
#(
    parameter int NODE_ID = 2,
    parameter int LINES   = 4,
    parameter int NUM_TOK = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_store,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_data,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_data,
    input  logic              ring_in_valid,
    output logic              ring_in_ready,
    input  logic [1:0]        ring_in_op,
    input  logic [ADDR_W-1:0] ring_in_addr,
    input  logic [DATA_W-1:0] ring_in_data,
    input  logic              ring_in_dv,
    input  logic [SRC_W-1:0]  ring_in_src,
    output logic              ring_out_valid,
    output logic [1:0]        ring_out_op,
    output logic [ADDR_W-1:0] ring_out_addr,
    output logic [DATA_W-1:0] ring_out_data,
    output logic              ring_out_dv,
    output logic [SRC_W-1:0]  ring_out_src
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam logic [ADDR_W-1:0] TOK_MASK = ADDR_W'(NUM_TOK - 1);
    localparam logic [SRC_W-1:0]  MY_ID    = SRC_W'(NODE_ID);

    function automatic logic [IDX_W-1:0] idx_of(logic [ADDR_W-1:0] a);
        return a[IDX_W-1:0];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:IDX_W];
    endfunction

    // registered state
    logic [1:0]        pend_q, pend_n;
    logic [ADDR_W-1:0] tok_q, tok_n;
    logic              wait_q, wait_n;
    logic              wst_q, wst_n;
    logic [ADDR_W-1:0] wad_q, wad_n;
    logic [DATA_W-1:0] wdt_q, wdt_n;
    logic              wb2_v_q, wb2_v_n;
    msg_t              wb2_q, wb2_n;
    logic              rout_v_q, rout_v_n;
    msg_t              rout_q, rout_n;
    logic              rsp_v_q, rsp_v_n;
    logic [DATA_W-1:0] rsp_d_q, rsp_d_n;

    // line store ports
    lstate_e           a_st, b_st, st_val;
    logic [TAG_W-1:0]  a_tag, b_tag, tg_val;
    logic [DATA_W-1:0] a_data, b_data, dt_val;
    logic              st_we, dt_we, tg_we;
    logic [IDX_W-1:0]  st_idx, dt_idx, tg_idx;

    // incoming message and lookups
    msg_t              rin;
    logic              rin_fire, own, r_hit, c_hit, c_local, cpu_fire;
    logic              cpu_wr_hit, victim;
    logic [DATA_W-1:0] snoop_data;
    msg_t              sn_out;
    logic              sn_we;
    lstate_e           sn_st;

    assign ring_in_ready = !wb2_v_q;
    assign cpu_req_ready = (pend_q == 2'd0) && !wait_q;

    assign rin      = mk_msg(op_e'(ring_in_op), ring_in_addr, ring_in_data,
                             ring_in_dv, ring_in_src);
    assign rin_fire = ring_in_valid && ring_in_ready;
    assign own      = (rin.src == MY_ID) && (rin.op != OP_TOK);
    assign cpu_fire = cpu_req_valid && cpu_req_ready;

    rcn_line_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .a_idx  (idx_of(rin.addr)),
        .a_st   (a_st),
        .a_tag  (a_tag),
        .a_data (a_data),
        .b_idx  (idx_of(cpu_req_addr)),
        .b_st   (b_st),
        .b_tag  (b_tag),
        .b_data (b_data),
        .st_we  (st_we),
        .st_idx (st_idx),
        .st_val (st_val),
        .dt_we  (dt_we),
        .dt_idx (dt_idx),
        .dt_val (dt_val),
        .tg_we  (tg_we),
        .tg_idx (tg_idx),
        .tg_val (tg_val)
    );

    assign r_hit      = (a_st != LS_I) && (a_tag == tag_of(rin.addr));
    assign c_hit      = (b_st != LS_I) && (b_tag == tag_of(cpu_req_addr));
    assign c_local    = c_hit && (!cpu_req_store || b_st == LS_M);
    assign cpu_wr_hit = cpu_fire && c_local && cpu_req_store;
    // a CPU store hit in the same cycle is ordered ahead of the snoop
    assign snoop_data = (cpu_wr_hit && idx_of(cpu_req_addr) == idx_of(rin.addr))
                        ? cpu_req_data : a_data;
    assign victim     = (a_st == LS_M) && (a_tag != tag_of(rin.addr));

    rcn_snoop u_snoop (
        .in_msg   (rin),
        .hit      (r_hit),
        .cur_st   (a_st),
        .cur_data (snoop_data),
        .out_msg  (sn_out),
        .st_we    (sn_we),
        .st_new   (sn_st)
    );

    always_comb begin
        pend_n   = pend_q;
        tok_n    = tok_q;
        wait_n   = wait_q;
        wst_n    = wst_q;
        wad_n    = wad_q;
        wdt_n    = wdt_q;
        wb2_v_n  = 1'b0;
        wb2_n    = wb2_q;
        rout_v_n = 1'b0;
        rout_n   = rin;
        rsp_v_n  = 1'b0;
        rsp_d_n  = rsp_d_q;
        st_we    = 1'b0;
        st_idx   = idx_of(rin.addr);
        st_val   = a_st;
        dt_we    = 1'b0;
        dt_idx   = idx_of(rin.addr);
        dt_val   = a_data;
        tg_we    = 1'b0;
        tg_idx   = idx_of(rin.addr);
        tg_val   = tag_of(rin.addr);

        if (wb2_v_q) begin
            rout_v_n = 1'b1;
            rout_n   = wb2_q;
        end

        if (rin_fire) begin
            if (rin.op == OP_TOK) begin
                if (wait_q && pend_q == 2'd0 && (wad_q & TOK_MASK) == rin.addr) begin
                    rout_v_n = 1'b1;
                    rout_n   = mk_msg(wst_q ? OP_WR : OP_RD, wad_q, '0, 1'b0, MY_ID);
                    pend_n   = 2'd1;
                    tok_n    = rin.addr;
                end else begin
                    rout_v_n = 1'b1;
                    rout_n   = rin;
                end
            end else if (own) begin
                if (rin.op == OP_RD || rin.op == OP_WR) begin
                    st_we    = 1'b1;
                    st_val   = (rin.op == OP_RD) ? LS_S : LS_M;
                    dt_we    = 1'b1;
                    dt_val   = (rin.op == OP_RD) ? rin.data : wdt_q;
                    tg_we    = 1'b1;
                    rsp_v_n  = 1'b1;
                    rsp_d_n  = dt_val;
                    wait_n   = 1'b0;
                    rout_v_n = 1'b1;
                    rout_n   = mk_msg(OP_WB, rin.addr, dt_val, 1'b1, MY_ID);
                    if (victim) begin
                        wb2_v_n = 1'b1;
                        wb2_n   = mk_msg(OP_WB, {a_tag, idx_of(rin.addr)}, a_data,
                                         1'b1, MY_ID);
                        pend_n  = 2'd2;
                    end
                end else begin
                    if (pend_q == 2'd2) begin
                        pend_n = 2'd1;
                    end else if (pend_q == 2'd1) begin
                        pend_n   = 2'd0;
                        rout_v_n = 1'b1;
                        rout_n   = mk_msg(OP_TOK, tok_q, '0, 1'b0, MY_ID);
                    end
                end
            end else begin
                rout_v_n = 1'b1;
                rout_n   = sn_out;
                st_we    = sn_we;
                st_val   = sn_st;
            end
        end

        if (cpu_fire) begin
            if (c_local) begin
                rsp_v_n = 1'b1;
                rsp_d_n = cpu_req_store ? cpu_req_data : b_data;
                if (cpu_req_store) begin
                    dt_we  = 1'b1;
                    dt_idx = idx_of(cpu_req_addr);
                    dt_val = cpu_req_data;
                end
            end else begin
                wait_n = 1'b1;
                wst_n  = cpu_req_store;
                wad_n  = cpu_req_addr;
                wdt_n  = cpu_req_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= 2'd0;
            tok_q    <= '0;
            wait_q   <= 1'b0;
            wst_q    <= 1'b0;
            wad_q    <= '0;
            wdt_q    <= '0;
            wb2_v_q  <= 1'b0;
            wb2_q    <= '0;
            rout_v_q <= 1'b0;
            rout_q   <= '0;
            rsp_v_q  <= 1'b0;
            rsp_d_q  <= '0;
        end else begin
            pend_q   <= pend_n;
            tok_q    <= tok_n;
            wait_q   <= wait_n;
            wst_q    <= wst_n;
            wad_q    <= wad_n;
            wdt_q    <= wdt_n;
            wb2_v_q  <= wb2_v_n;
            wb2_q    <= wb2_n;
            rout_v_q <= rout_v_n;
            rout_q   <= rout_n;
            rsp_v_q  <= rsp_v_n;
            rsp_d_q  <= rsp_d_n;
        end
    end

    assign cpu_rsp_valid  = rsp_v_q;
    assign cpu_rsp_data   = rsp_d_q;
    assign ring_out_valid = rout_v_q;
    assign ring_out_op    = rout_q.op;
    assign ring_out_addr  = rout_q.addr;
    assign ring_out_data  = rout_q.data;
    assign ring_out_dv    = rout_q.dv;
    assign ring_out_src   = rout_q.src;

    // R11: the pending counter never takes its unused code
    p_pend_legal_r11: assert property (@(posedge clk) disable iff (rst)
        pend_q != 2'd3);

    // R3: a held token is never on the ring output while transactions are open
    p_hold_token_r3: assert property (@(posedge clk) disable iff (rst)
        (pend_q != 2'd0) |-> !(rout_v_q && rout_q.op == OP_TOK && rout_q.addr == tok_q));

    // R3: an own request leaving the node always opens exactly one transaction
    p_req_opens_r3: assert property (@(posedge clk) disable iff (rst)
        (rout_v_q && rout_q.src == MY_ID && (rout_q.op == OP_RD || rout_q.op == OP_WR))
        |-> pend_q == 2'd1);

    // R10: entering pending 2 coincides with a WriteBack on the output
    p_wb2_entry_r10: assert property (@(posedge clk) disable iff (rst)
        (pend_q == 2'd2 && $past(pend_q) != 2'd2) |-> (rout_v_q && rout_q.op == OP_WB));

    // R10: the ring input stall lasts a single cycle
    p_stall_once_r10: assert property (@(posedge clk) disable iff (rst)
        !ring_in_ready |=> ring_in_ready);

    // R12: no CPU response appears while a request waits for its token
    p_no_rsp_wait_r12: assert property (@(posedge clk) disable iff (rst)
        (wait_q && $past(wait_q)) |-> !rsp_v_q);

endmodule

// File: tb/tb_rcn_node.sv
module tb_rcn_node;
    import rcn_pkg::*;

    localparam int ID = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cpu_req_valid = 1'b0;
    logic              cpu_req_ready;
    logic              cpu_req_store = 1'b0;
    logic [ADDR_W-1:0] cpu_req_addr = '0;
    logic [DATA_W-1:0] cpu_req_data = '0;
    logic              cpu_rsp_valid;
    logic [DATA_W-1:0] cpu_rsp_data;
    logic              ring_in_valid = 1'b0;
    logic              ring_in_ready;
    logic [1:0]        ring_in_op = '0;
    logic [ADDR_W-1:0] ring_in_addr = '0;
    logic [DATA_W-1:0] ring_in_data = '0;
    logic              ring_in_dv = 1'b0;
    logic [SRC_W-1:0]  ring_in_src = '0;
    logic              ring_out_valid;
    logic [1:0]        ring_out_op;
    logic [ADDR_W-1:0] ring_out_addr;
    logic [DATA_W-1:0] ring_out_data;
    logic              ring_out_dv;
    logic [SRC_W-1:0]  ring_out_src;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rcn_node #(.NODE_ID(ID), .LINES(4), .NUM_TOK(2)) dut (
        .clk(clk), .rst(rst),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_store(cpu_req_store), .cpu_req_addr(cpu_req_addr),
        .cpu_req_data(cpu_req_data), .cpu_rsp_valid(cpu_rsp_valid),
        .cpu_rsp_data(cpu_rsp_data), .ring_in_valid(ring_in_valid),
        .ring_in_ready(ring_in_ready), .ring_in_op(ring_in_op),
        .ring_in_addr(ring_in_addr), .ring_in_data(ring_in_data),
        .ring_in_dv(ring_in_dv), .ring_in_src(ring_in_src),
        .ring_out_valid(ring_out_valid), .ring_out_op(ring_out_op),
        .ring_out_addr(ring_out_addr), .ring_out_data(ring_out_data),
        .ring_out_dv(ring_out_dv), .ring_out_src(ring_out_src)
    );

    function automatic logic [DATA_W-1:0] dfill(logic [ADDR_W-1:0] a);
        return DATA_W'(16'h1000 + a * 16'h0101);
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // drive one ring message for one cycle, return at the sampling point
    task automatic ring_send(logic [1:0] op, logic [ADDR_W-1:0] a,
                             logic [DATA_W-1:0] d, logic dv, logic [SRC_W-1:0] s);
        ring_in_valid = 1'b1;
        ring_in_op    = op;
        ring_in_addr  = a;
        ring_in_data  = d;
        ring_in_dv    = dv;
        ring_in_src   = s;
        @(posedge clk);
        @(negedge clk);
        ring_in_valid = 1'b0;
    endtask

    task automatic cpu_send(logic st, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        cpu_req_valid = 1'b1;
        cpu_req_store = st;
        cpu_req_addr  = a;
        cpu_req_data  = d;
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
    endtask

    task automatic chk_out(string req, logic [1:0] op, logic [ADDR_W-1:0] a,
                           logic [DATA_W-1:0] d, logic dv, logic [SRC_W-1:0] s);
        chk(req, "out valid", ring_out_valid, 1);
        chk(req, "out op", ring_out_op, op);
        chk(req, "out addr", ring_out_addr, a);
        chk(req, "out data", ring_out_data, d);
        chk(req, "out dv", ring_out_dv, dv);
        chk(req, "out src", ring_out_src, s);
    endtask

    // full miss / upgrade flow through the ring
    task automatic fill(logic st, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] rdata,
                        logic [DATA_W-1:0] wdata, string req);
        logic [DATA_W-1:0] exp = st ? wdata : rdata;
        logic [ADDR_W-1:0] grp = ADDR_W'(a[0]);
        cpu_send(st, a, wdata);
        chk(req, "no immediate rsp", cpu_rsp_valid, 0);
        chk("R12", "ready low while waiting", cpu_req_ready, 0);
        ring_send(2'd3, grp ^ 1, 16'h0, 1'b0, 4'd1);
        chk_out("R4", 2'd3, grp ^ 1, 16'h0, 1'b0, 4'd1);
        ring_send(2'd3, grp, 16'h0, 1'b0, 4'd1);
        chk_out("R3", st ? 2'd1 : 2'd0, a, 16'h0, 1'b0, 4'(ID));
        chk("R12", "ready low while pending", cpu_req_ready, 0);
        ring_send(st ? 2'd1 : 2'd0, a, rdata, 1'b1, 4'(ID));
        chk(st ? "R9" : "R8", "rsp valid", cpu_rsp_valid, 1);
        chk(st ? "R9" : "R8", "rsp data", cpu_rsp_data, exp);
        chk_out(st ? "R9" : "R8", 2'd2, a, exp, 1'b1, 4'(ID));
        ring_send(2'd2, a, exp, 1'b1, 4'(ID));
        chk_out("R11", 2'd3, grp, 16'h0, 1'b0, 4'(ID));
        chk("R12", "ready back", cpu_req_ready, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "out valid", ring_out_valid, 0);
        chk("R1", "rsp valid", cpu_rsp_valid, 0);
        chk("R1", "cpu ready", cpu_req_ready, 1);
        chk("R1", "ring ready", ring_in_ready, 1);

        // load every line index through the ring
        for (int a = 0; a < 4; a++) begin
            fill(1'b0, ADDR_W'(a), dfill(ADDR_W'(a)), 16'h0, "R1");
            cpu_send(1'b0, ADDR_W'(a), 16'h0);
            chk("R2", "load hit rsp", cpu_rsp_valid, 1);
            chk("R2", "load hit data", cpu_rsp_data, dfill(ADDR_W'(a)));
            chk("R2", "no ring msg", ring_out_valid, 0);
        end

        // foreign reads over hitting and non-hitting addresses
        for (int a = 0; a < 8; a++) begin
            ring_send(2'd0, ADDR_W'(a), 16'h5555, 1'b0, 4'd5);
            if (a < 4) chk_out("R6", 2'd0, ADDR_W'(a), dfill(ADDR_W'(a)), 1'b1, 4'd5);
            else       chk_out("R5", 2'd0, ADDR_W'(a), 16'h5555, 1'b0, 4'd5);
        end
        ring_send(2'd2, 8'd1, 16'h4242, 1'b1, 4'd6);
        chk_out("R5", 2'd2, 8'd1, 16'h4242, 1'b1, 4'd6);

        // store upgrade of a Shared line, then local store hit
        fill(1'b1, 8'd2, 16'h0, 16'hBEEF, "R3");
        cpu_send(1'b1, 8'd2, 16'hCAFE);
        chk("R2", "store hit rsp", cpu_rsp_valid, 1);
        chk("R2", "store hit data", cpu_rsp_data, 16'hCAFE);
        chk("R2", "no ring msg", ring_out_valid, 0);
        cpu_send(1'b0, 8'd2, 16'h0);
        chk("R2", "stored value", cpu_rsp_data, 16'hCAFE);

        // foreign read downgrades M to S
        ring_send(2'd0, 8'd2, 16'h0, 1'b0, 4'd5);
        chk_out("R6", 2'd0, 8'd2, 16'hCAFE, 1'b1, 4'd5);
        fill(1'b1, 8'd2, 16'h0, 16'h1234, "R6");

        // eviction of a Modified victim
        cpu_send(1'b1, 8'd6, 16'h5678);
        chk("R3", "no immediate rsp", cpu_rsp_valid, 0);
        ring_send(2'd3, 8'd0, 16'h0, 1'b0, 4'd1);
        chk_out("R3", 2'd1, 8'd6, 16'h0, 1'b0, 4'(ID));
        ring_send(2'd1, 8'd6, 16'h0, 1'b1, 4'(ID));
        chk("R9", "rsp data", cpu_rsp_data, 16'h5678);
        chk_out("R9", 2'd2, 8'd6, 16'h5678, 1'b1, 4'(ID));
        chk("R10", "ring stall", ring_in_ready, 0);
        @(posedge clk);
        @(negedge clk);
        chk_out("R10", 2'd2, 8'd2, 16'h1234, 1'b1, 4'(ID));
        chk("R10", "ring ready again", ring_in_ready, 1);
        ring_send(2'd2, 8'd6, 16'h5678, 1'b1, 4'(ID));
        chk("R11", "2 to 1 silent", ring_out_valid, 0);
        ring_send(2'd2, 8'd2, 16'h1234, 1'b1, 4'(ID));
        chk_out("R11", 2'd3, 8'd0, 16'h0, 1'b0, 4'(ID));
        cpu_send(1'b1, 8'd6, 16'h9999);
        chk("R9", "line installed M", cpu_rsp_valid, 1);

        // foreign write invalidates a Shared line
        ring_send(2'd1, 8'd1, 16'h0, 1'b0, 4'd7);
        chk_out("R7", 2'd1, 8'd1, dfill(8'd1), 1'b1, 4'd7);
        fill(1'b0, 8'd1, 16'h7777, 16'h0, "R7");
        ring_send(2'd1, 8'h45, 16'h3131, 1'b0, 4'd7);
        chk_out("R5", 2'd1, 8'h45, 16'h3131, 1'b0, 4'd7);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule